// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits between a synchronous host and an asynchronous 16K x 8 parallel read-only memory. The host offers a 14-bit byte address with a valid/ready handshake. The controller then drives the memory address lines and pulls the active-low chip-select and read-enable strobes low together. It waits a fixed number of clock cycles, samples the 8-bit data lines, and returns the byte with a one-cycle response strobe.

The wait is computed at elaboration from the clock period and four memory timing limits, all given in picoseconds. These are the address-to-data time, the select-to-data time, the read-enable-to-data time and the output-float time. Each limit is rounded up to whole cycles. Sampling waits for the largest of the three access counts. After each read, the controller keeps both strobes high and refuses new requests for the float count. This lets the memory release the data lines before the next access or another bus agent drives them. Changing the speed grade only needs new parameter values.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n` and `mem_oe_n` are high and `rsp_valid` and `req_ready` are low. `req_ready` first goes high after the second rising clock edge that follows the release of `rst_n`.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. From that edge on, `mem_ce_n` and `mem_oe_n` are low, `mem_addr` carries the request address and `req_ready` is low.
- R3: The access count is WAIT = max(1, ceil(T_ACC/CLK), ceil(T_CE/CLK), ceil(T_OE/CLK)). With the default parameters WAIT is 4. `rsp_valid` is high in the cycle after the WAIT-th rising edge that follows the acceptance edge, and at no other time.
- R4: `rsp_data` equals the byte present on `mem_dq` at the capture edge, which is the WAIT-th edge after acceptance. At that edge, all three access limits measured from the address change, the select fall and the read-enable fall have elapsed. The value is held until the next capture.
- R5: `mem_addr` does not change while `mem_ce_n` is low. It keeps the last accepted address until the next acceptance.
- R6: `mem_ce_n` and `mem_oe_n` return high on the capture edge, so they are high in the cycle where `rsp_valid` is high.
- R7: The float count is DF = ceil(T_DF/CLK), which is 2 with the default parameters. After the capture edge, `req_ready` stays low for DF cycles. The earliest next acceptance therefore comes at least DF cycles after the strobes rose, when the memory no longer drives `mem_dq`.
- R8: Each accepted request produces exactly one `rsp_valid` cycle.
- R9: `req_valid` and `req_addr` have no effect while `req_ready` is low. The bus strobes, the address lines and the response keep following the access already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 14 | Byte address of the request |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` holds the byte just read |
| rsp_data | output | 8 | Byte read from the memory |
| mem_addr | output | 14 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_dq | input | 8 | Memory data lines |

## Verification
The bench models the memory so that it returns a corrupted byte until every access limit has elapsed. If the controller samples one cycle too early, the captured byte is wrong, and a mistake in the largest of the three counts shows up as a late or early response strobe. The bench keeps `req_valid` high through streams of back-to-back reads and changes `req_addr` while the controller is busy. A controller that skips or shortens the float gap would start the next access while the memory still drives the data lines. A controller that listens while busy would move the address lines in the middle of an access. The extreme addresses 0 and 16383 and alternating bit patterns check that all address and data bits pass through correctly.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_t;

  // Round a time in picoseconds up to whole clock cycles
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_rst_sync.sv
module eprom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/eprom_wait_ctr.sv
module eprom_wait_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero = (cnt_q == '0);

  // Counter runs down to zero and parks there until reloaded
  always_comb begin
    cnt_en = load || !zero;
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/eprom_rd_fsm.sv
module eprom_rd_fsm
  import eprom_rd_pkg::*;
#(
  parameter int WAIT_CYC = 4,
  parameter int DF_CYC   = 2,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          ctr_zero,
  output logic          ctr_load,
  output logic [CW-1:0] ctr_val,
  output logic          accept,
  output logic          capture,
  output logic          idle
);

  localparam logic [CW-1:0] WAIT_LD = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] DF_LD   = CW'((DF_CYC > 0) ? (DF_CYC - 1) : 0);
  localparam bit            HAS_GAP = (DF_CYC > 0);

  rd_state_t state_q;
  rd_state_t state_d;

  always_comb begin
    state_d  = state_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          ctr_load = 1'b1;
          ctr_val  = WAIT_LD;
          state_d  = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (ctr_zero) begin
          capture = 1'b1;
          if (HAS_GAP) begin
            ctr_load = 1'b1;
            ctr_val  = DF_LD;
            state_d  = ST_FLOAT;
          end else begin
            state_d  = ST_IDLE;
          end
        end
      end
      ST_FLOAT: begin
        if (ctr_zero) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign idle = (state_q == ST_IDLE);

endmodule

// File: rtl/eprom_bus_io.sv
module eprom_bus_io #(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] mem_dq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          ce_n_q, oe_n_q, vld_q;
  logic          ce_n_d, oe_n_d;
  logic          strobe_en;

  always_comb begin
    strobe_en = accept || capture;
    ce_n_d    = capture;
    oe_n_d    = capture;
  end

  // Address and capture registers: clock enables only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (capture) begin
      data_q <= mem_dq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
    end else if (strobe_en) begin
      ce_n_q <= ce_n_d;
      oe_n_q <= oe_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= capture;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_oe_n  = oe_n_q;
  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 10000,
  parameter int T_ACC_PS = 35000,
  parameter int T_CE_PS  = 35000,
  parameter int T_OE_PS  = 20000,
  parameter int T_DF_PS  = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam int ACC_CYC  = cyc_ceil(T_ACC_PS, CLK_PS);
  localparam int CE_CYC   = cyc_ceil(T_CE_PS, CLK_PS);
  localparam int OE_CYC   = cyc_ceil(T_OE_PS, CLK_PS);
  localparam int WAIT_CYC = max_int(1, max_int(ACC_CYC, max_int(CE_CYC, OE_CYC)));
  localparam int DF_CYC   = cyc_ceil(T_DF_PS, CLK_PS);
  localparam int CNT_MAX  = max_int(WAIT_CYC, DF_CYC);
  localparam int CW       = max_int(1, $clog2(CNT_MAX + 1));

  logic          rst_n_s;
  logic          ctr_load, ctr_zero;
  logic [CW-1:0] ctr_val;
  logic          accept, capture, idle;
  logic          req_go;

  eprom_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign req_ready = idle && rst_n_s;
  assign req_go    = req_valid && rst_n_s;

  eprom_rd_fsm #(
    .WAIT_CYC (WAIT_CYC),
    .DF_CYC   (DF_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_go),
    .ctr_zero  (ctr_zero),
    .ctr_load  (ctr_load),
    .ctr_val   (ctr_val),
    .accept    (accept),
    .capture   (capture),
    .idle      (idle)
  );

  eprom_wait_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (ctr_load),
    .load_val (ctr_val),
    .zero     (ctr_zero)
  );

  eprom_bus_io #(.AW(ADDR_W), .DW(DATA_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .mem_dq    (mem_dq),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk #(
  parameter int AW       = 14,
  parameter int WAIT_CYC = 4,
  parameter int DF_CYC   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n
);

  logic [15:0] acc_len;

  // Length of the current select-low run, in clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_len <= '0;
    end else if (mem_ce_n) begin
      acc_len <= '0;
    end else begin
      acc_len <= acc_len + 16'd1;
    end
  end

  // R2
  accept_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_ce_n && !mem_oe_n && !req_ready));

  // R3
  wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (acc_len == 16'(WAIT_CYC)));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R6
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_ce_n && mem_oe_n && !$past(mem_ce_n)));

  // R7
  float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((DF_CYC > 0) && $rose(mem_oe_n)) |-> !req_ready);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
  .AW       (ADDR_W),
  .WAIT_CYC (WAIT_CYC),
  .DF_CYC   (DF_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/sim_eprom_rd_ctrl.sv
module sim_eprom_rd_ctrl;

  localparam int CLK_NS = 10;
  localparam int HALF   = CLK_NS / 2;
  localparam int T_ACC  = 35;
  localparam int T_CE   = 35;
  localparam int T_OE   = 20;
  localparam int T_DF   = 20;
  localparam int WAIT_E = 4;   // largest access limit, rounded up: 35 ns / 10 ns
  localparam int DF_E   = 2;   // 20 ns / 10 ns

  logic        clk, rst_n, req_valid, req_ready, rsp_valid, mem_ce_n, mem_oe_n;
  logic [13:0] req_addr, mem_addr;
  logic [7:0]  rsp_data, dq_m;

  int checks = 0;
  int errors = 0;

  eprom_rd_ctrl #(
    .CLK_PS(CLK_NS * 1000), .T_ACC_PS(T_ACC * 1000), .T_CE_PS(T_CE * 1000),
    .T_OE_PS(T_OE * 1000), .T_DF_PS(T_DF * 1000)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(dq_m)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  function automatic logic [7:0] content(input logic [13:0] a);
    return (a[7:0] ^ {2'b00, a[13:8]}) + 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---- memory model: timestamps of bus events, validity at the coming edge
  int   t_addr = -1000, t_ce = -1000, t_oe = -1000, t_off = -1000;
  logic [13:0] p_addr = '0;
  logic p_ce = 1'b1, p_oe = 1'b1;
  bit   dq_ok = 1'b0, dq_drv = 1'b0;

  // ---- reference model state
  int   m_state = 0;  // 0 idle, 1 access, 2 float
  int   m_cnt = 0, rel_cnt = 0;
  bit   m_rsp = 1'b0;
  logic [13:0] m_addr = '0;
  logic [7:0]  m_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; rel_cnt = 0; m_rsp = 1'b0; m_addr = '0; m_data = '0;
    end else begin
      m_rsp = 1'b0;
      case (m_state)
        0: if (req_valid && rel_cnt >= 2) begin
             // R7: memory must have released the data lines
             chk(!dq_drv, "R7 bus still driven at acceptance", int'(dq_drv), 0);
             m_addr = req_addr; m_cnt = 0; m_state = 1;
           end
        1: begin
             m_cnt++;
             if (m_cnt == WAIT_E) begin
               // R4: every access limit has elapsed at the sampling edge
               chk(dq_ok, "R4 sampled before data valid", int'(dq_ok), 1);
               m_data = content(m_addr); m_rsp = 1'b1; m_cnt = 0;
               m_state = (DF_E > 0) ? 2 : 0;
             end
           end
        default: begin
             m_cnt++;
             if (m_cnt == DF_E) m_state = 0;
           end
      endcase
      if (rel_cnt < 2) rel_cnt++;
    end
  end

  always @(negedge clk) begin
    int now, nxt;
    now = int'($time);
    nxt = now + HALF;
    if (mem_addr !== p_addr) t_addr = now - HALF;
    if (!mem_ce_n && p_ce) t_ce = now - HALF;
    if (!mem_oe_n && p_oe) t_oe = now - HALF;
    if ((mem_ce_n && !p_ce) || (mem_oe_n && !p_oe)) t_off = now - HALF;
    p_addr = mem_addr; p_ce = mem_ce_n; p_oe = mem_oe_n;
    dq_ok  = !mem_ce_n && !mem_oe_n && (nxt - t_addr >= T_ACC) &&
             (nxt - t_ce >= T_CE) && (nxt - t_oe >= T_OE);
    dq_drv = (!mem_ce_n && !mem_oe_n) || (nxt - t_off < T_DF);
    dq_m   = dq_ok ? content(mem_addr) : ~content(mem_addr);

    // cycle-by-cycle comparison against the reference model
    if (!rst_n) begin
      chk(mem_ce_n && mem_oe_n, "R1 strobes in reset", int'({mem_ce_n, mem_oe_n}), 3);
      chk(!rsp_valid && !req_ready, "R1 handshake in reset", int'({rsp_valid, req_ready}), 0);
    end else begin
      chk(req_ready === (m_state == 0 && rel_cnt >= 2), "R1 R7 req_ready",
          int'(req_ready), int'(m_state == 0 && rel_cnt >= 2));
      chk(mem_ce_n === (m_state != 1), "R2 R6 mem_ce_n", int'(mem_ce_n), int'(m_state != 1));
      chk(mem_oe_n === (m_state != 1), "R2 R6 mem_oe_n", int'(mem_oe_n), int'(m_state != 1));
      // R5, R9: address follows only accepted requests
      chk(mem_addr === m_addr, "R5 R9 mem_addr", int'(mem_addr), int'(m_addr));
      chk(rsp_valid === m_rsp, "R3 R8 rsp_valid", int'(rsp_valid), int'(m_rsp));
      if (m_rsp) chk(rsp_data === m_data, "R4 rsp_data", int'(rsp_data), int'(m_data));
    end
  end

  task automatic do_read(input logic [13:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;   // R9: changes while busy must be ignored
    repeat (WAIT_E + DF_E + 2) @(negedge clk);
  endtask

  task automatic stream(input logic [13:0] list [5]);
    @(negedge clk);
    req_valid = 1'b1;
    foreach (list[i]) begin
      req_addr = list[i];   // set while busy: R9
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic run_test();
    logic [13:0] s1 [5];
    s1 = '{14'h1555, 14'h0ABC, 14'h3001, 14'h0001, 14'h3FFE};
    rst_n = 1'b0; req_valid = 1'b0; req_addr = 14'h2222;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(14'h0000);
    do_read(14'h3FFF);
    do_read(14'h2AAA);
    stream(s1);
    repeat (3) @(negedge clk);
    // R9: request held with valid across a long idle before it
    req_addr = 14'h0F0F;
    repeat (2) @(negedge clk);
    do_read(14'h1234);
    stream('{14'h0000, 14'h3FFF, 14'h0000, 14'h3FFF, 14'h2A55});
    repeat (WAIT_E + DF_E + 6) @(negedge clk);
  endtask

  initial begin
    fork
      run_test();
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R8 watchdog act=%0d exp=%0d", 20000, 0);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule